// File: doc/BRIEF.md
# Four-Way Write-Back Cache Controller

This block is a unified last-level cache that sits between a single request port (driven by address translation logic) and a main-memory port. It holds 128-bit lines in four ways per set, uses a three-bit tree pseudo-LRU per set to pick victims, and follows a write-back, write-allocate policy. One request is in flight at a time. A cacheable request is accepted in the idle state and passes a fixed lookup pipeline: two cycles of registered array read, one cycle of tag comparison and one cycle of hit/miss resolution with word selection.

On a hit, a load returns the selected 32-bit word and a store merges its bytes into the line and marks the line dirty. On a miss, the victim way named by the pseudo-LRU tree is first written back to memory if it is valid and dirty. The line is then fetched and installed, and the pending access completes against it. Requests whose top address bit is set are peripheral accesses. They never touch the arrays and go to memory as a single uncached word transfer.

The memory port uses a request/ready handshake. The block holds `mem_req` and its fields until a cycle in which `mem_ready` is high. In that cycle the transfer completes, and for a read `mem_rdata` is taken.

Top module: `wbcache_ctrl`

## Requirements
- R1: While reset is asserted, `req_ready` is 1 and `resp_valid` and `mem_req` are 0. All lines are invalid after reset, so the first cacheable access to any address misses.
- R2: A load hit returns the 32-bit word at address bits [3:2] of the line on `resp_rdata`. `resp_valid` is seen exactly 5 cycles after the accepting clock edge, and there is no memory traffic.
- R3: A store hit writes the bytes of `req_wdata` whose `req_be` bit is 1 (bit b drives byte b) into the word selected by address bits [3:2]. Its response comes 6 cycles after acceptance, with no memory traffic.
- R4: A miss issues exactly one line read (`mem_we`=0, `mem_uncached`=0) at the request address with bits [3:0] cleared. The refilled data then serves the access.
- R5: When the victim way is valid and dirty, its whole line is written to memory before the refill read, at address {victim tag, index, 4'b0}. The written data is the line's current contents.
- R6: A store miss allocates: the line is filled, the store bytes are merged, and the line is dirty, so a later load hits with the merged value.
- R7: Each set has a tree of three bits t0 (root), t1 and t2, all 0 after reset. The victim is way {1,t2} when t0=1 and way {0,t1} when t0=0. A hit or refill of way w sets t0=~w[1] and sets t1 (w<2) or t2 (w>=2) to ~w[0].
- R8: A request with address bit 31 set makes one uncached transfer (`mem_uncached`=1) at the full request address, with `req_wdata` on `mem_wdata[31:0]` and `req_be` on `mem_be` for stores. A load returns `mem_rdata[31:0]`. The cache arrays are left untouched.
- R9: `req_ready` is 1 only in the idle state. `resp_valid` is a single-cycle pulse, and `req_ready` is 0 while it is high.
- R10: While `mem_req` is 1 and `mem_ready` is 0, `mem_req`, `mem_addr`, `mem_we` and `mem_uncached` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present; taken when `req_ready` is 1 |
| req_we | input | 1 | 1 = store, 0 = load |
| req_addr | input | 32 | Byte address; bit 31 selects the peripheral range |
| req_wdata | input | 32 | Store data |
| req_be | input | 4 | Store byte enables |
| req_ready | output | 1 | Idle and able to take a request |
| resp_valid | output | 1 | One-cycle completion pulse |
| resp_rdata | output | 32 | Load data, valid with `resp_valid` |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = write transfer |
| mem_uncached | output | 1 | 1 = single-word peripheral transfer |
| mem_addr | output | 32 | Transfer address |
| mem_wdata | output | 128 | Line write-back data, or the store word in bits [31:0] |
| mem_be | output | 4 | Byte enables for uncached writes |
| mem_ready | input | 1 | Transfer completes in this cycle |
| mem_rdata | input | 128 | Read data, taken when `mem_ready` is 1 |

## Verification
A corrupted tag, valid or dirty bit shows up at the ports on the next access to the same set. A hit turns into an unexpected refill read, or a write-back appears, is missing, or carries the wrong address or data. A bad pseudo-LRU tree shows up as the wrong victim address on the next miss in that set. A merge fault shows up as the wrong word on the next load from that line. The bench models the tags, dirty bits and replacement tree and checks the memory traffic, latency and data of every request, so such faults appear within a few requests to the affected set.

// File: rtl/wbc_pkg.sv
`timescale 1ns/1ps
package wbc_pkg;
  localparam int WAYS   = 4;
  localparam int WAY_W  = 2;
  localparam int LINE_W = 128;
  localparam int WORD_W = 32;
  localparam int OFF_W  = 4;
  localparam int WPL    = LINE_W / WORD_W;

  typedef enum logic [3:0] {
    ST_IDLE, ST_RD1, ST_RD2, ST_CMP, ST_SEL, ST_LWR,
    ST_WB, ST_MRD, ST_PWR, ST_PRD, ST_RESP
  } wbc_state_e;

  // tree walk: root bit picks the pair, leaf bit picks the way
  function automatic logic [WAY_W-1:0] plru_pick(input logic [2:0] t);
    return t[0] ? {1'b1, t[2]} : {1'b0, t[1]};
  endfunction

  // point every bit on the path of w away from w
  function automatic logic [2:0] plru_mark(input logic [2:0] t, input logic [WAY_W-1:0] w);
    logic [2:0] n;
    n    = t;
    n[0] = ~w[1];
    if (w[1]) n[2] = ~w[0];
    else      n[1] = ~w[0];
    return n;
  endfunction
endpackage

// File: rtl/wbc_plru.sv
`timescale 1ns/1ps
module wbc_plru #(
  parameter int SETS = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [$clog2(SETS)-1:0]  rd_idx,
  input  logic                     touch_en,
  input  logic [$clog2(SETS)-1:0]  touch_idx,
  input  logic [wbc_pkg::WAY_W-1:0] touch_way,
  output logic [wbc_pkg::WAY_W-1:0] victim
);
  import wbc_pkg::*;

  logic [2:0] tree_q [SETS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) tree_q[s] <= 3'b000;
    end else if (touch_en) begin
      tree_q[touch_idx] <= plru_mark(tree_q[touch_idx], touch_way);
    end
  end

  assign victim = plru_pick(tree_q[rd_idx]);

  // R7: a way just used is never the next victim of its set
  p_touch_away_r7: assert property (@(posedge clk) disable iff (!rst_n)
    touch_en |=> ($past(touch_idx) != rd_idx) || (victim != $past(touch_way)));
endmodule

// File: rtl/wbc_tag_cmp.sv
`timescale 1ns/1ps
module wbc_tag_cmp #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 24
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic [WAYS-1:0]         way_vld,
  input  logic [WAYS*TAG_W-1:0]   way_tag,
  input  logic [TAG_W-1:0]        ref_tag,
  output logic [WAYS-1:0]         hit_q
);
  for (genvar g = 0; g < WAYS; g++) begin : g_way
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  hit_q[g] <= 1'b0;
      else if (en) hit_q[g] <= way_vld[g] && (way_tag[g*TAG_W +: TAG_W] == ref_tag);
    end
  end

  // R2: a set never holds the same valid tag twice
  p_hit_unique_r2: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(hit_q));
endmodule

// File: rtl/wbc_merge.sv
`timescale 1ns/1ps
module wbc_merge (
  input  logic [wbc_pkg::LINE_W-1:0] base,
  input  logic [wbc_pkg::WORD_W-1:0] word,
  input  logic [3:0]                 be,
  input  logic [1:0]                 sel,
  output logic [wbc_pkg::LINE_W-1:0] merged
);
  import wbc_pkg::*;

  for (genvar w = 0; w < WPL; w++) begin : g_word
    for (genvar b = 0; b < 4; b++) begin : g_byte
      assign merged[w*WORD_W + b*8 +: 8] =
        (sel == 2'(w) && be[b]) ? word[b*8 +: 8] : base[w*WORD_W + b*8 +: 8];
    end
  end
endmodule

// File: rtl/wbcache_ctrl.sv
`timescale 1ns/1ps
module wbcache_ctrl #(
  parameter int ADDR_W     = 32,
  parameter int SETS       = 16,
  parameter int PERIPH_BIT = 31
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic                req_we,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [31:0]         req_wdata,
  input  logic [3:0]          req_be,
  output logic                req_ready,
  output logic                resp_valid,
  output logic [31:0]         resp_rdata,
  output logic                mem_req,
  output logic                mem_we,
  output logic                mem_uncached,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [127:0]        mem_wdata,
  output logic [3:0]          mem_be,
  input  logic                mem_ready,
  input  logic [127:0]        mem_rdata
);
  import wbc_pkg::*;

  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

  // reset: asserted at once, released on the clock
  logic [1:0] rs_q;
  logic       rst_ns;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_ns = rs_q[1];

  wbc_state_e state_q, state_d;
  logic [ADDR_W-1:0] a_q;
  logic              we_q;
  logic [31:0]       wd_q, rdata_q;
  logic [3:0]        be_q;
  logic [WAY_W-1:0]  way_q, hway, victim;

  logic [WAYS-1:0]   vld_q   [SETS];
  logic [WAYS-1:0]   drt_mem [SETS];
  logic [TAG_W-1:0]  tag_mem [SETS][WAYS];
  logic [LINE_W-1:0] dat_mem [SETS][WAYS];

  logic [WAYS-1:0]   v1_q, v2_q, dt1_q, dt2_q, hit_q;
  logic [TAG_W-1:0]  t1_q [WAYS];
  logic [TAG_W-1:0]  t2_q [WAYS];
  logic [LINE_W-1:0] l1_q [WAYS];
  logic [LINE_W-1:0] l2_q [WAYS];
  logic [WAYS*TAG_W-1:0] t2_flat;

  logic [IDX_W-1:0] idx;
  logic [TAG_W-1:0] tag;
  logic [1:0]       wsel;
  logic             acc, hit, fill_done, touch_en;
  logic [LINE_W-1:0] merge_base, merged;

  assign idx  = a_q[OFF_W +: IDX_W];
  assign tag  = a_q[ADDR_W-1 -: TAG_W];
  assign wsel = a_q[3:2];
  assign acc  = (state_q == ST_IDLE) && req_valid;
  assign hit  = |hit_q;
  assign fill_done = (state_q == ST_MRD) && mem_ready;

  always_comb begin
    hway = '0;
    for (int w = 0; w < WAYS; w++) if (hit_q[w]) hway = WAY_W'(w);
  end

  // next state
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (req_valid) state_d = req_addr[PERIPH_BIT] ? (req_we ? ST_PWR : ST_PRD) : ST_RD1;
      ST_RD1:  state_d = ST_RD2;
      ST_RD2:  state_d = ST_CMP;
      ST_CMP:  state_d = ST_SEL;
      ST_SEL:  if (hit)                            state_d = we_q ? ST_LWR : ST_RESP;
               else if (v2_q[victim] && dt2_q[victim]) state_d = ST_WB;
               else                                state_d = ST_MRD;
      ST_LWR:  state_d = ST_RESP;
      ST_WB:   if (mem_ready) state_d = ST_MRD;
      ST_MRD:  if (mem_ready) state_d = ST_RESP;
      ST_PWR:  if (mem_ready) state_d = ST_RESP;
      ST_PRD:  if (mem_ready) state_d = ST_RESP;
      ST_RESP: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  // valid bits carry reset; the rest of the arrays do not
  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
    end else if (fill_done) begin
      vld_q[idx][way_q] <= 1'b1;
    end
  end

  // request capture and response word
  always_ff @(posedge clk) begin
    if (acc) begin
      a_q  <= req_addr;
      we_q <= req_we;
      wd_q <= req_wdata;
      be_q <= req_be;
    end
    if (state_q == ST_SEL) way_q <= hit ? hway : victim;
    if ((state_q == ST_SEL) && hit) rdata_q <= l2_q[hway][wsel*WORD_W +: WORD_W];
    else if (fill_done)             rdata_q <= mem_rdata[wsel*WORD_W +: WORD_W];
    else if ((state_q == ST_PRD) && mem_ready) rdata_q <= mem_rdata[WORD_W-1:0];
  end

  // array writes: store hit merge or refill
  assign merge_base = (state_q == ST_MRD) ? mem_rdata : l2_q[way_q];

  always_ff @(posedge clk) begin
    if (state_q == ST_LWR) begin
      dat_mem[idx][way_q] <= merged;
      drt_mem[idx][way_q] <= 1'b1;
    end else if (fill_done) begin
      dat_mem[idx][way_q] <= we_q ? merged : mem_rdata;
      drt_mem[idx][way_q] <= we_q;
      tag_mem[idx][way_q] <= tag;
    end
  end

  // two-stage registered array read
  for (genvar g = 0; g < WAYS; g++) begin : g_rd
    always_ff @(posedge clk) begin
      if (state_q == ST_RD1) begin
        v1_q[g]  <= vld_q[idx][g];
        dt1_q[g] <= drt_mem[idx][g];
        t1_q[g]  <= tag_mem[idx][g];
        l1_q[g]  <= dat_mem[idx][g];
      end
      if (state_q == ST_RD2) begin
        v2_q[g]  <= v1_q[g];
        dt2_q[g] <= dt1_q[g];
        t2_q[g]  <= t1_q[g];
        l2_q[g]  <= l1_q[g];
      end
    end
    assign t2_flat[g*TAG_W +: TAG_W] = t2_q[g];
  end

  wbc_tag_cmp #(.WAYS(WAYS), .TAG_W(TAG_W)) u_cmp (
    .clk(clk), .rst_n(rst_ns), .en(state_q == ST_CMP),
    .way_vld(v2_q), .way_tag(t2_flat), .ref_tag(tag), .hit_q(hit_q)
  );

  assign touch_en = ((state_q == ST_SEL) && hit) || fill_done;

  wbc_plru #(.SETS(SETS)) u_plru (
    .clk(clk), .rst_n(rst_ns), .rd_idx(idx), .touch_en(touch_en), .touch_idx(idx),
    .touch_way((state_q == ST_SEL) ? hway : way_q), .victim(victim)
  );

  wbc_merge u_merge (
    .base(merge_base), .word(wd_q), .be(be_q), .sel(wsel), .merged(merged)
  );

  // port outputs
  assign req_ready    = (state_q == ST_IDLE);
  assign resp_valid   = (state_q == ST_RESP);
  assign resp_rdata   = rdata_q;
  assign mem_req      = (state_q == ST_WB) || (state_q == ST_MRD) ||
                        (state_q == ST_PWR) || (state_q == ST_PRD);
  assign mem_we       = (state_q == ST_WB) || (state_q == ST_PWR);
  assign mem_uncached = (state_q == ST_PWR) || (state_q == ST_PRD);
  assign mem_be       = (state_q == ST_PWR) ? be_q : 4'h0;

  always_comb begin
    mem_addr  = a_q;
    mem_wdata = '0;
    if (state_q == ST_WB) begin
      mem_addr  = {t2_q[way_q], idx, {OFF_W{1'b0}}};
      mem_wdata = l2_q[way_q];
    end else if (state_q == ST_MRD) begin
      mem_addr  = {tag, idx, {OFF_W{1'b0}}};
    end else if (state_q == ST_PWR) begin
      mem_wdata = {{(LINE_W-WORD_W){1'b0}}, wd_q};
    end
  end

  p_resp_pulse_r9: assert property (@(posedge clk) disable iff (!rst_ns)
    resp_valid |=> !resp_valid);
  p_busy_r9: assert property (@(posedge clk) disable iff (!rst_ns)
    resp_valid |-> !req_ready);
  p_mem_hold_r10: assert property (@(posedge clk) disable iff (!rst_ns)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_uncached));
  p_wb_then_fill_r5: assert property (@(posedge clk) disable iff (!rst_ns)
    mem_req && mem_we && !mem_uncached && mem_ready |=> mem_req && !mem_we && !mem_uncached);
  p_line_align_r4: assert property (@(posedge clk) disable iff (!rst_ns)
    mem_req && !mem_uncached |-> mem_addr[OFF_W-1:0] == '0);
endmodule

// File: tb/wbcache_ctrl_tb_top.sv
`timescale 1ns/1ps
module wbcache_ctrl_tb_top;
  logic clk, rst_n;
  logic req_valid, req_we, req_ready, resp_valid;
  logic [31:0] req_addr, req_wdata, resp_rdata, mem_addr;
  logic [3:0] req_be, mem_be;
  logic mem_req, mem_we, mem_uncached, mem_ready;
  logic [127:0] mem_wdata, mem_rdata;

  wbcache_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_be(req_be), .req_ready(req_ready), .resp_valid(resp_valid),
    .resp_rdata(resp_rdata), .mem_req(mem_req), .mem_we(mem_we), .mem_uncached(mem_uncached),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_ready(mem_ready),
    .mem_rdata(mem_rdata)
  );

  int total = 0, bad = 0;
  bit done = 0;

  // golden coherent view and backing memory, 256 lines
  logic [127:0] gmem [256];
  logic [127:0] bmem [256];
  // model of tags, dirty bits and replacement trees
  logic        mv [16][4];
  logic        md [16][4];
  logic [23:0] mt [16][4];
  logic [2:0]  mp [16];

  int n_wb, n_rd, n_pw, n_pr, rd_after_wb;
  logic [31:0] wb_addr, rd_addr, p_addr, p_wdata;
  logic [3:0]  p_be;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", rq, what, act, exp);
    end
  endtask

  function automatic int m_victim(input logic [2:0] t);
    if (t[0]) return t[2] ? 3 : 2;
    return t[1] ? 1 : 0;
  endfunction

  function automatic logic [2:0] m_touch(input logic [2:0] t, input int w);
    logic [2:0] n;
    n = t;
    if (w < 2) begin n[0] = 1'b1; n[1] = (w == 0); end
    else       begin n[0] = 1'b0; n[2] = (w == 2); end
    return n;
  endfunction

  initial begin
    clk = 0;
    forever #4 clk = ~clk;
  end

  // memory and peripheral responder
  initial begin
    bit busy;
    int wcnt;
    logic [31:0] hold_addr;
    logic hold_we;
    busy = 0; wcnt = 0;
    mem_ready = 0; mem_rdata = '0;
    forever begin
      @(negedge clk);
      if (mem_ready) mem_ready = 0;
      else if (mem_req) begin
        if (!busy) begin
          busy = 1; hold_addr = mem_addr; hold_we = mem_we; wcnt = $urandom % 3;
        end
        if (wcnt > 0) wcnt--;
        else begin
          chk(mem_addr == hold_addr && mem_we == hold_we, "R10", "request held until ready",
              {96'h0, mem_addr}, {96'h0, hold_addr});
          if (mem_uncached) begin
            p_addr = mem_addr;
            if (mem_we) begin n_pw++; p_wdata = mem_wdata[31:0]; p_be = mem_be; end
            else begin n_pr++; mem_rdata = {96'h0, mem_addr ^ 32'h5A5A0F0F}; end
          end else if (mem_we) begin
            n_wb++; wb_addr = mem_addr;
            chk(mem_wdata == gmem[mem_addr[11:4]], "R5", "write-back data", mem_wdata, gmem[mem_addr[11:4]]);
            bmem[mem_addr[11:4]] = mem_wdata;
          end else begin
            n_rd++; rd_addr = mem_addr; rd_after_wb = n_wb;
            mem_rdata = bmem[mem_addr[11:4]];
          end
          mem_ready = 1; busy = 0;
        end
      end
    end
  end

  task automatic access(input bit we, input logic [31:0] addr, input logic [31:0] wd,
                        input logic [3:0] be, input string lbl);
    int s, ln, ws, hw, vw, n, way;
    bit hit, exp_wb;
    logic [23:0] tg;
    logic [31:0] exp_wba, exp_rd;
    s = addr[7:4]; ln = addr[11:4]; ws = addr[3:2]; tg = addr[31:8];
    hit = 0; hw = 0;
    for (int w = 0; w < 4; w++) if (mv[s][w] && mt[s][w] == tg) begin hit = 1; hw = w; end
    vw = m_victim(mp[s]);
    exp_wb = !hit && mv[s][vw] && md[s][vw];
    exp_wba = {mt[s][vw], 4'(s), 4'h0};
    exp_rd = addr[31] ? (addr ^ 32'h5A5A0F0F) : gmem[ln][32*ws +: 32];
    n_wb = 0; n_rd = 0; n_pw = 0; n_pr = 0; rd_after_wb = 0;

    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_we = we; req_addr = addr; req_wdata = wd; req_be = be;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    n = 1;
    chk(!req_ready, "R9", "not ready while busy", {127'h0, req_ready}, 128'h0);
    while (!resp_valid && n < 400) begin @(negedge clk); n++; end
    chk(resp_valid, "R9", "response pulse seen", {127'h0, resp_valid}, 128'h1);
    chk(!req_ready, "R9", "not ready during response", {127'h0, req_ready}, 128'h0);

    if (!we) chk(resp_rdata == exp_rd, lbl, "load data", {96'h0, resp_rdata}, {96'h0, exp_rd});
    if (addr[31]) begin
      chk(n_pw == int'(we) && n_pr == int'(!we) && n_wb == 0 && n_rd == 0, "R8",
          "one uncached transfer", n_pw + 2*n_pr + 4*n_wb + 8*n_rd, we ? 1 : 2);
      chk(p_addr == addr, "R8", "uncached address", {96'h0, p_addr}, {96'h0, addr});
      if (we) chk(p_wdata == wd && p_be == be, "R8", "uncached store word/enables",
                  {92'h0, p_be, p_wdata}, {92'h0, be, wd});
    end else if (hit) begin
      chk(n_wb + n_rd == 0, "R2 R7", "no traffic on hit", n_wb + n_rd, 0);
      chk(n == (we ? 6 : 5), we ? "R3" : "R2", "hit latency", n, we ? 6 : 5);
    end else begin
      chk(n_rd == 1 && rd_addr == {addr[31:4], 4'h0}, "R4 R7", "refill read",
          {96'h0, rd_addr}, {96'h0, addr[31:4], 4'h0});
      chk(n_wb == int'(exp_wb), "R5 R7", "write-back count", n_wb, int'(exp_wb));
      if (exp_wb) chk(wb_addr == exp_wba && rd_after_wb == 1, "R5", "victim address and order",
                      {96'h0, wb_addr}, {96'h0, exp_wba});
    end

    if (!addr[31]) begin
      way = hit ? hw : vw;
      if (!hit) begin mv[s][way] = 1; mt[s][way] = tg; md[s][way] = 0; end
      if (we) md[s][way] = 1;
      mp[s] = m_touch(mp[s], way);
      if (we) for (int b = 0; b < 4; b++) if (be[b]) gmem[ln][32*ws + 8*b +: 8] = wd[8*b +: 8];
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run did not finish act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 256; i++) begin
      for (int k = 0; k < 4; k++) gmem[i][32*k +: 32] = 32'hC000_0000 | (i << 8) | k;
      bmem[i] = gmem[i];
    end
    for (int s = 0; s < 16; s++) begin
      mp[s] = 3'b000;
      for (int w = 0; w < 4; w++) begin mv[s][w] = 0; md[s][w] = 0; mt[s][w] = '0; end
    end
    req_valid = 0; req_we = 0; req_addr = '0; req_wdata = '0; req_be = '0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk(req_ready && !resp_valid && !mem_req, "R1", "reset outputs",
        {125'h0, req_ready, resp_valid, mem_req}, 128'h4);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // first access after reset must miss
    access(0, 32'h0000_0348, '0, '0, "R1");
    chk(n_rd == 1, "R1", "first access misses", n_rd, 1);
    access(0, 32'h0000_0344, '0, '0, "R2");
    // store hit with partial enables, then read back
    access(1, 32'h0000_0348, 32'hDEAD_BEEF, 4'b0101, "R3");
    access(0, 32'h0000_0348, '0, '0, "R3");
    // fill set 3 and check the tree order
    access(0, 32'h0000_0130, '0, '0, "R7");
    access(0, 32'h0000_0230, '0, '0, "R7");
    access(0, 32'h0000_0430, '0, '0, "R7");
    access(0, 32'h0000_0030, '0, '0, "R7");
    access(0, 32'h0000_0530, '0, '0, "R7");
    access(0, 32'h0000_0030, '0, '0, "R7");
    chk(n_rd == 0, "R7", "recently used line kept", n_rd, 0);
    // store miss allocates, then dirty victim write-back
    access(1, 32'h0000_0A5C, 32'h1234_5678, 4'b1111, "R6");
    chk(n_rd == 1 && n_wb == 0, "R6", "store miss fills first", n_rd + 4*n_wb, 1);
    access(0, 32'h0000_0A5C, '0, '0, "R6");
    chk(n_rd == 0, "R6", "allocated line hits", n_rd, 0);
    for (int t = 0; t < 6; t++) access(0, {20'h0, 4'(t), 8'h50}, '0, '0, "R5");
    // peripheral range
    access(1, 32'h8000_0124, 32'hCAFE_F00D, 4'b0011, "R8");
    access(0, 32'h8000_0040, '0, '0, "R8");
    access(0, 32'h0000_0344, '0, '0, "R8");

    for (int i = 0; i < 1500; i++) begin
      logic [31:0] a;
      bit w;
      if ($urandom % 10 == 0) a = 32'h8000_0000 | ($urandom & 32'h0000_FFFC);
      else a = {20'h0, 4'($urandom % 6), 4'($urandom), 2'($urandom), 2'b00};
      w = ($urandom % 10) < 4;
      access(w, a, $urandom, 4'($urandom), a[31] ? "R8" : "R2");
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule